// File: doc/BRIEF.md
# Shared-Bank Odd-Multiple Multiplier

This block multiplies an unsigned operand by an unsigned coefficient without a partial-product array. A bank first forms every odd multiple of the operand that a 4-bit digit can need: 1x, 3x, 5x, 7x, 9x, 11x, 13x and 15x. Each of these is built from shifts and adds only. The coefficient is cut into 4-bit digits, and each digit has its own selector. The selector removes the digit's trailing zeros, and the odd part that remains picks one bank entry. The selector then shifts that entry left by the number of zeros it removed. A digit equal to zero is forced to contribute nothing.

The selector outputs are weighted by their digit position, 4 bits per step. They are merged in carry-save form and resolved by one carry-propagate adder. The operand and the coefficient are registered on entry, and the product is registered on exit. Because the bank depends only on the operand, several coefficient selectors can share one bank. The top module here instantiates one set of selectors.

Top module: `odd_multiple_mult`

## Requirements
- R1: `prod_o` equals the unsigned product `x_i * coef_i`, 32 bits wide, with no truncation.
- R2: Operands present at rising edge n appear as a product on `prod_o` after edge n+1. The product holds that value until edge n+2.
- R3: While `rst` is high at a rising edge, both input registers and `prod_o` clear to 0. The first product after `rst` falls is therefore 0, and real products follow from the next edge.
- R4: A coefficient of 0 gives a product of 0 for any operand.
- R5: A coefficient digit (bits 4p+3..4p) equal to 0 adds nothing, while the other digits still add their full weight. For example, `coef_i = 16'h0F00` gives `x * 16'h0F00`.
- R6: A coefficient with a single bit k set gives `x << k` for every k from 0 to 15. This covers the digit values 2, 4 and 8, which are served by shifting the 1x entry back up.
- R7: All-ones operands (`16'hFFFF` times `16'hFFFF`) give `32'hFFFE0001`.
- R8: Every digit value from 1 to 15, placed alone in any of the four digit positions p, gives `x * v * 16^p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 16 | Unsigned operand shared by all digit selectors |
| coef_i | input | 16 | Unsigned coefficient, split into four 4-bit digits |
| prod_o | output | 32 | Registered unsigned product |

## Verification
Suppose a bank entry is wrong, say 11x built with a wrong shift. The error then appears only for coefficients that have a digit of 11, and it shows two edges after those operands were presented, scaled by that digit's weight. The single-digit sweep over all values and positions therefore pins a fault to one entry and one position. A selector that gets its trailing-zero count wrong breaks only the even digits, which the single-bit sweep isolates. A missing zero mask shows up as a nonzero product for a zero coefficient in the very next product. Every fault is confined to one product, because no state lives past the output register.

// File: rtl/oddmul_pkg.sv
package oddmul_pkg;
  // Default geometry shared by the multiplier and its checker.
  localparam int OPW_DEF = 16;   // operand width
  localparam int CFW_DEF = 16;   // coefficient width
  localparam int DGW_DEF = 4;    // coefficient digit width

  // Odd multiplier held in bank slot k.
  function automatic int odd_of_slot(input int k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/oddmul_bank.sv
// Bank of odd multiples of the operand, built with shift-and-add only.
module oddmul_bank
  import oddmul_pkg::*;
#(
  parameter int OPW = OPW_DEF,
  parameter int DGW = DGW_DEF,
  localparam int NSLOT = 2 ** (DGW - 1),
  localparam int BW = OPW + DGW
) (
  input  logic [OPW-1:0]              x_i,
  output logic [NSLOT-1:0][BW-1:0]    mult_o
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam int MUL = odd_of_slot(k);
    logic [BW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int b = 0; b < DGW; b++) begin
        if (MUL[b]) acc = acc + (BW'(x_i) << b);
      end
    end
    assign mult_o[k] = acc;
  end
endmodule

// File: rtl/oddmul_select.sv
// One digit selector: strip trailing zeros, pick odd multiple, shift back, mask zero.
module oddmul_select
  import oddmul_pkg::*;
#(
  parameter int OPW = OPW_DEF,
  parameter int DGW = DGW_DEF,
  localparam int NSLOT = 2 ** (DGW - 1),
  localparam int BW = OPW + DGW,
  localparam int IW = DGW - 1,
  localparam int TZW = (DGW > 1) ? $clog2(DGW) : 1
) (
  input  logic [DGW-1:0]           dig_i,
  input  logic [NSLOT-1:0][BW-1:0] mult_i,
  output logic [BW-1:0]            part_o
);
  logic [TZW-1:0] tz;
  logic [IW-1:0]  slot;
  logic [BW-1:0]  picked;
  logic           nonzero;

  always_comb begin
    tz = '0;
    for (int b = DGW - 1; b >= 0; b--) begin
      if (dig_i[b]) tz = TZW'(b);
    end
  end

  assign nonzero = |dig_i;
  assign slot    = IW'((dig_i >> tz) >> 1);
  assign picked  = mult_i[slot] << tz;
  assign part_o  = nonzero ? picked : '0;
endmodule

// File: rtl/oddmul_sum.sv
// Weights each digit term by position, merges in carry-save form, one final add.
module oddmul_sum
  import oddmul_pkg::*;
#(
  parameter int OPW = OPW_DEF,
  parameter int CFW = CFW_DEF,
  parameter int DGW = DGW_DEF,
  localparam int NDIG = CFW / DGW,
  localparam int BW = OPW + DGW,
  localparam int PW = OPW + CFW
) (
  input  logic [NDIG-1:0][BW-1:0] part_i,
  output logic [PW-1:0]           sum_o
);
  logic [NDIG-1:0][PW-1:0] weighted;
  logic [PW-1:0] s_vec, c_vec;

  for (genvar g = 0; g < NDIG; g++) begin : g_weight
    assign weighted[g] = PW'(part_i[g]) << (DGW * g);
  end

  always_comb begin
    logic [PW-1:0] ns, nc;
    s_vec = weighted[0];
    c_vec = '0;
    for (int g = 1; g < NDIG; g++) begin
      ns = s_vec ^ c_vec ^ weighted[g];
      nc = ((s_vec & c_vec) | (s_vec & weighted[g]) | (c_vec & weighted[g])) << 1;
      s_vec = ns;
      c_vec = nc;
    end
  end

  assign sum_o = s_vec + c_vec;
endmodule

// File: rtl/odd_multiple_mult.sv
// Top: input registers, shared bank, per-digit selectors, summation, output register.
module odd_multiple_mult
  import oddmul_pkg::*;
#(
  parameter int OPW = OPW_DEF,
  parameter int CFW = CFW_DEF,
  parameter int DGW = DGW_DEF,
  localparam int NDIG = CFW / DGW,
  localparam int NSLOT = 2 ** (DGW - 1),
  localparam int BW = OPW + DGW,
  localparam int PW = OPW + CFW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] x_i,
  input  logic [CFW-1:0] coef_i,
  output logic [PW-1:0]  prod_o
);
  logic [OPW-1:0] x_q;
  logic [CFW-1:0] coef_q;
  logic [NSLOT-1:0][BW-1:0] mult;
  logic [NDIG-1:0][BW-1:0]  part;
  logic [PW-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      coef_q <= '0;
    end else begin
      x_q    <= x_i;
      coef_q <= coef_i;
    end
  end

  oddmul_bank #(.OPW(OPW), .DGW(DGW)) u_bank (
    .x_i    (x_q),
    .mult_o (mult)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    oddmul_select #(.OPW(OPW), .DGW(DGW)) u_sel (
      .dig_i  (coef_q[DGW*g +: DGW]),
      .mult_i (mult),
      .part_o (part[g])
    );
  end

  oddmul_sum #(.OPW(OPW), .CFW(CFW), .DGW(DGW)) u_sum (
    .part_i (part),
    .sum_o  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_o <= '0;
    else     prod_o <= sum;
  end
endmodule

// File: rtl/odd_multiple_mult_chk.sv
module odd_multiple_mult_chk
  import oddmul_pkg::*;
#(
  parameter int OPW = OPW_DEF,
  parameter int CFW = CFW_DEF,
  localparam int PW = OPW + CFW
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] x_i,
  input logic [CFW-1:0] coef_i,
  input logic [PW-1:0]  prod_o
);
  logic [1:0] live;

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (live >= 2'd2) |-> prod_o == PW'(PW'($past(x_i, 2)) * PW'($past(coef_i, 2))));  // R1

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd3 && $past(x_i, 2) == $past(x_i, 3) && $past(coef_i, 2) == $past(coef_i, 3))
    |-> $stable(prod_o));  // R2

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> prod_o == '0);  // R3

  AST_ZERO_COEF: assert property (@(posedge clk) disable iff (rst)
    (live >= 2'd2 && $past(coef_i, 2) == '0) |-> prod_o == '0);  // R4
endmodule

bind odd_multiple_mult odd_multiple_mult_chk #(.OPW(OPW), .CFW(CFW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .x_i    (x_i),
  .coef_i (coef_i),
  .prod_o (prod_o)
);

// File: tb/test_odd_multiple_mult.sv
module test_odd_multiple_mult;
  // 8-unit period: 125 MHz with 1 ns time units.
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] x_i = '0;
  logic [15:0] coef_i = '0;
  logic [31:0] prod_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  odd_multiple_mult i_odd_multiple_mult (
    .clk(clk), .rst(rst), .x_i(x_i), .coef_i(coef_i), .prod_o(prod_o)
  );

  localparam int NVEC = 12;
  localparam logic [NVEC-1:0][31:0] VEC = {
    {16'h0001, 16'h0001}, {16'h1234, 16'h5678}, {16'hFFFF, 16'h0001},
    {16'h0001, 16'hFFFF}, {16'hA5A5, 16'h5A5A}, {16'h8000, 16'h8000},
    {16'h00FF, 16'hFF00}, {16'hBEEF, 16'h0F0F}, {16'h7FFF, 16'h9999},
    {16'h0003, 16'hEDCB}, {16'hC001, 16'h3210}, {16'h2468, 16'hACE1}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] xv, input logic [15:0] cv, input string req);
    @(negedge clk);
    x_i = xv;
    coef_i = cv;
    @(negedge clk);
    @(negedge clk);
    check(req, prod_o, 32'(xv) * 32'(cv));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R3: reset state
    x_i = 16'hFFFF;
    coef_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R3 reset holds product at zero", prod_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 first product after reset", prod_o, 32'h0);
    @(negedge clk);
    check("R7 all-ones operands", prod_o, 32'hFFFE0001);

    // R1: vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][31:16], VEC[i][15:0], "R1 table product");
    end

    // R2: latency and hold
    apply(16'h1111, 16'h0007, "R2 product A");
    @(negedge clk);
    x_i = 16'h2222;
    coef_i = 16'h0009;
    @(negedge clk);
    check("R2 old product held one edge", prod_o, 32'h1111 * 32'h7);
    @(negedge clk);
    check("R2 new product after second edge", prod_o, 32'h2222 * 32'h9);

    // R4: zero coefficient
    apply(16'hFFFF, 16'h0000, "R4 zero coefficient");
    apply(16'h1357, 16'h0000, "R4 zero coefficient");

    // R5: zero digits masked
    apply(16'hBEEF, 16'h0F00, "R5 zero digits");
    apply(16'hFFFF, 16'hF00F, "R5 zero digits");
    apply(16'h1234, 16'h00A0, "R5 zero digits");

    // R6: single-bit coefficients
    for (int k = 0; k < 16; k++) begin
      apply(16'hD00D, 16'(1) << k, "R6 single bit");
    end

    // R7: all ones
    apply(16'hFFFF, 16'hFFFF, "R7 all-ones operands");

    // R8: every digit value in every position
    for (int p = 0; p < 4; p++) begin
      for (int v = 1; v < 16; v++) begin
        apply(16'hBEEF, 16'(v) << (4 * p), "R8 digit sweep");
      end
    end

    // R1: random operands
    for (int i = 0; i < 200; i++) begin
      apply(16'($urandom), 16'($urandom), "R1 random product");
    end

    // R3: reset in mid-run
    @(negedge clk);
    x_i = 16'h4321;
    coef_i = 16'h8765;
    rst = 1'b1;
    @(negedge clk);
    check("R3 mid-run reset clears product", prod_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 cleared registers give zero", prod_o, 32'h0);
    @(negedge clk);
    check("R1 product after reset release", prod_o, 32'h4321 * 32'h8765);

    done = 1'b1;
    finish_run();
  end
endmodule